// File: doc/BRIEF.md
# Serial GPIO Scan Master

This block keeps a set of remote general-purpose I/O lines in step with two parallel words inside the chip, using a three-wire serial link plus a return data line. While it is enabled it runs one frame after another with no gap. Each frame moves one bit per bus clock cycle. Output values go out on the serial-out line, and the remote input values arrive on the serial-in line during the same frame.

No address travels on the link. The receiver tells the bits apart only by counting bus clock cycles from the load strobe. The load strobe covers the cycle of the final bit of every frame. The bus clock is divided down from the system clock by a programmable amount. The output word is sampled once per frame. The input word is replaced in one step at the end of each frame and flagged with a single-cycle pulse.

Top module: `sio_scan_master`

## Requirements
- R1: While reset is held and after it is released, the outputs are: bus clock high, load strobe low, serial-out low, input word zero and update pulse low.
- R2: When the enable is low, or the line count is zero, no frame starts. The bus clock stays high and the load strobe and update pulse stay low.
- R3: While enabled with a non-zero line count N, frames follow each other without gaps. Each frame is exactly N bus clock cycles long and carries one bit per cycle.
- R4: Each half of a bus clock cycle, low and high, lasts divider+1 system clock cycles. The divider value is taken at the start of each frame.
- R5: Serial-out carries output bit i during bus clock cycle i of a frame, with bit 0 first. It changes only together with a falling edge of the bus clock. Output bits at index N and above are never sent.
- R6: A bus clock cycle runs from one falling edge to the next. The load strobe is high for the whole of the last bus clock cycle of a frame and low for every other bit.
- R7: Serial-in is sampled at the rising edge of bus clock cycle i, and the sample becomes input bit i.
- R8: All bits of the input word change together at the end of a frame. Bits at index N and above read zero. The update pulse is high for exactly the one system clock cycle in which the new word first appears.
- R9: The output word is sampled when a frame starts. A change made while a frame is running appears in the following frame.
- R10: A change to the line count or a clear of the enable takes effect only at a frame boundary. A frame that has started always runs to its full length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run frames while high |
| divider | input | 8 | Half-period of the bus clock, minus one, in system clocks |
| lineCount | input | 6 | Number of GPIO lines per frame; values above 32 act as 32 |
| outWord | input | 32 | Parallel output values, bit 0 sent first |
| inWord | output | 32 | Parallel input values from the last completed frame |
| inUpdate | output | 1 | One-cycle pulse when inWord is refreshed |
| busClk | output | 1 | Serial bus clock, idles high |
| loadStrobe | output | 1 | Frame marker, high during the last bit |
| serOut | output | 1 | Serial output data |
| serIn | input | 1 | Serial input data |

## Verification
The serial link has no addressing, so an off-by-one in the bit index or frame length shows at once. The strobe lands on the wrong bus clock cycle, and every later bit of that frame is credited to the wrong line, both in the recovered output pattern and in the refreshed input word at the next update pulse. A wrong divider or phase state shows within one bus clock half-period as a low or high phase of the wrong length. A control path that acts on a setting in the middle of a frame shows in the first frame after the change, because that frame then has the new length or pattern when it should still carry the old one.

// File: rtl/sio_scan_pkg.sv
package sio_scan_pkg;
  // Per-cycle commands from the frame control to the shift datapath
  typedef struct packed {
    logic startFrame;  // falling edge of bit 0: latch output word, clear capture
    logic shiftNext;   // falling edge of a later bit: present next output bit
    logic sampleIn;    // rising edge: capture serial input
    logic endFrame;    // end of last bit: publish captured word
  } scanStrobe_t;
endpackage

// File: rtl/sio_scan_ctrl.sv
module sio_scan_ctrl
  import sio_scan_pkg::*;
#(
  parameter int MAX_LINES = 32,
  parameter int DIV_W     = 8,
  localparam int CNT_W    = $clog2(MAX_LINES + 1),
  localparam int IDX_W    = $clog2(MAX_LINES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [DIV_W-1:0] divider,
  input  logic [CNT_W-1:0] lineCount,
  output scanStrobe_t      strobe,
  output logic [IDX_W-1:0] bitIdx,
  output logic             busClk,
  output logic             loadStrobe
);

  logic             running;
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divLat;
  logic [CNT_W-1:0] frameLen;
  logic [CNT_W-1:0] effCount;
  logic             tick;
  logic             lastBit;
  logic             canStart;

  always_comb begin
    effCount = (lineCount > CNT_W'(MAX_LINES)) ? CNT_W'(MAX_LINES) : lineCount;
    canStart = enable && (effCount != '0);
    tick     = running && (divCnt == divLat);
    lastBit  = (CNT_W'(bitIdx) + CNT_W'(1)) == frameLen;
    strobe.sampleIn   = tick && !busClk;
    strobe.endFrame   = tick && busClk && lastBit;
    strobe.shiftNext  = tick && busClk && !lastBit;
    strobe.startFrame = (!running && canStart) || (strobe.endFrame && canStart);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running    <= 1'b0;
      busClk     <= 1'b1;
      divCnt     <= '0;
      divLat     <= '0;
      bitIdx     <= '0;
      frameLen   <= '0;
      loadStrobe <= 1'b0;
    end else if (strobe.startFrame) begin
      running    <= 1'b1;
      busClk     <= 1'b0;
      divCnt     <= '0;
      divLat     <= divider;
      bitIdx     <= '0;
      frameLen   <= effCount;
      loadStrobe <= (effCount == CNT_W'(1));
    end else if (strobe.shiftNext) begin
      busClk     <= 1'b0;
      divCnt     <= '0;
      bitIdx     <= bitIdx + 1'b1;
      loadStrobe <= (CNT_W'(bitIdx) + CNT_W'(2)) == frameLen;
    end else if (strobe.sampleIn) begin
      busClk <= 1'b1;
      divCnt <= '0;
    end else if (strobe.endFrame) begin
      running    <= 1'b0;
      divCnt     <= '0;
      loadStrobe <= 1'b0;
    end else if (running) begin
      divCnt <= divCnt + 1'b1;
    end
  end

  AST_IDLE_BUS: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> (busClk && !loadStrobe)); // R2
  AST_DIV_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    running |-> (divCnt <= divLat)); // R4
  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    running |-> (CNT_W'(bitIdx) < frameLen)); // R3
  AST_STROBE_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (running && !busClk) |-> (loadStrobe == lastBit)); // R6

endmodule

// File: rtl/sio_scan_dpath.sv
module sio_scan_dpath
  import sio_scan_pkg::*;
#(
  parameter int MAX_LINES = 32,
  localparam int IDX_W    = $clog2(MAX_LINES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  scanStrobe_t          strobe,
  input  logic [IDX_W-1:0]     bitIdx,
  input  logic [MAX_LINES-1:0] outWord,
  input  logic                 serIn,
  output logic                 serOut,
  output logic [MAX_LINES-1:0] inWord,
  output logic                 inUpdate
);

  logic [MAX_LINES-1:0] outShift;
  logic [MAX_LINES-1:0] capture;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outShift <= '0;
      serOut   <= 1'b0;
    end else if (strobe.startFrame) begin
      outShift <= outWord >> 1;
      serOut   <= outWord[0];
    end else if (strobe.shiftNext) begin
      outShift <= outShift >> 1;
      serOut   <= outShift[0];
    end
  end

  // One capture flop per line, written when its index is sampled
  for (genvar g = 0; g < MAX_LINES; g++) begin : gCapture
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        capture[g] <= 1'b0;
      end else if (strobe.startFrame) begin
        capture[g] <= 1'b0;
      end else if (strobe.sampleIn && (bitIdx == IDX_W'(g))) begin
        capture[g] <= serIn;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inWord   <= '0;
      inUpdate <= 1'b0;
    end else begin
      inUpdate <= strobe.endFrame;
      if (strobe.endFrame) inWord <= capture;
    end
  end

  AST_UPDATE_ONE: assert property (@(posedge clk) disable iff (!rstN)
    inUpdate |=> !inUpdate); // R8
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !inUpdate |-> $stable(inWord)); // R8

endmodule

// File: rtl/sio_scan_master.sv
module sio_scan_master
  import sio_scan_pkg::*;
#(
  parameter int MAX_LINES = 32,
  parameter int DIV_W     = 8,
  localparam int CNT_W    = $clog2(MAX_LINES + 1),
  localparam int IDX_W    = $clog2(MAX_LINES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 enable,
  input  logic [DIV_W-1:0]     divider,
  input  logic [CNT_W-1:0]     lineCount,
  input  logic [MAX_LINES-1:0] outWord,
  output logic [MAX_LINES-1:0] inWord,
  output logic                 inUpdate,
  output logic                 busClk,
  output logic                 loadStrobe,
  output logic                 serOut,
  input  logic                 serIn
);

  scanStrobe_t      strobe;
  logic [IDX_W-1:0] bitIdx;

  sio_scan_ctrl #(.MAX_LINES(MAX_LINES), .DIV_W(DIV_W)) uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable), .divider(divider),
    .lineCount(lineCount), .strobe(strobe), .bitIdx(bitIdx),
    .busClk(busClk), .loadStrobe(loadStrobe)
  );

  sio_scan_dpath #(.MAX_LINES(MAX_LINES)) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .bitIdx(bitIdx),
    .outWord(outWord), .serIn(serIn), .serOut(serOut),
    .inWord(inWord), .inUpdate(inUpdate)
  );

  AST_SEROUT_FALL: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(serOut) |-> $fell(busClk)); // R5

endmodule

// File: tb/sio_scan_master_test.sv
module sio_scan_master_test;
  localparam int MAXL = 32;

  typedef struct packed {
    logic [5:0]  cnt;
    logic [7:0]  div;
    logic [31:0] outv;
    logic [31:0] inv;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{6'd16, 8'd0, 32'h0000_A5C3, 32'h0000_3C5A},
    '{6'd1,  8'd1, 32'h0000_0001, 32'h0000_0001},
    '{6'd32, 8'd0, 32'h9E37_79B9, 32'h6A09_E667},
    '{6'd7,  8'd2, 32'h0000_0055, 32'h0000_002A},
    '{6'd3,  8'd0, 32'hFFFF_FFFA, 32'hFFFF_FFFF},
    '{6'd5,  8'd3, 32'h0000_001F, 32'h0000_0011}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic [7:0]  divider = '0;
  logic [5:0]  lineCount = '0;
  logic [31:0] outWord = '0;
  logic [31:0] inWord;
  logic        inUpdate;
  logic        busClk;
  logic        loadStrobe;
  logic        serOut;
  logic        serIn = 1'b0;

  int checks = 0;
  int fails = 0;

  // Remote expander model and frame monitor
  logic [63:0] remote = '0;
  logic [63:0] obs = '0;
  logic [63:0] lastOut = '0;
  int pos = 0;
  int lastLen = 0;
  int frameDone = 0;

  always #2 clk = ~clk;

  sio_scan_master uut (
    .clk(clk), .rstN(rstN), .enable(enable), .divider(divider),
    .lineCount(lineCount), .outWord(outWord), .inWord(inWord),
    .inUpdate(inUpdate), .busClk(busClk), .loadStrobe(loadStrobe),
    .serOut(serOut), .serIn(serIn)
  );

  initial begin
    forever begin
      @(negedge busClk);
      serIn = (pos < 64) ? remote[pos] : 1'b0;
      @(posedge busClk);
      if (pos < 64) obs[pos] = serOut;
      if (loadStrobe) begin
        lastLen = pos + 1;
        lastOut = obs;
        obs = '0;
        pos = 0;
        frameDone++;
      end else if (pos < 63) begin
        pos++;
      end
    end
  end

  function automatic logic [63:0] maskOf(int n);
    return (n >= 64) ? '1 : ((64'd1 << n) - 64'd1);
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitUpdate();
    do @(negedge clk); while (!inUpdate);
  endtask

  task automatic waitFrames(int n);
    int target = frameDone + n;
    while (frameDone < target) @(negedge clk);
  endtask

  task automatic idleWatch(string tag, int cycles);
    int bad = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (!busClk || loadStrobe || inUpdate) bad++;
    end
    chk(tag, bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R3 watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    vec_t prev;
    repeat (3) @(negedge clk);
    // R1 reset values while held and after release
    chk("R1 busClk", busClk, 1);
    chk("R1 loadStrobe", loadStrobe, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 serOut", serOut, 0);
    chk("R1 inWord", inWord, 0);
    chk("R1 inUpdate", inUpdate, 0);

    // Vector table: each entry changes settings mid-frame
    lineCount = VEC[0].cnt; divider = VEC[0].div;
    outWord = VEC[0].outv; remote = {32'd0, VEC[0].inv};
    enable = 1'b1;
    waitUpdate();
    for (int i = 0; i < 6; i++) begin
      prev = (i == 0) ? VEC[0] : VEC[i-1];
      lineCount = VEC[i].cnt; divider = VEC[i].div;
      outWord = VEC[i].outv; remote = {32'd0, VEC[i].inv};
      waitFrames(1);
      chk("R10 old length", lastLen, prev.cnt);
      chk("R10 old pattern", lastOut, {32'd0, prev.outv} & maskOf(prev.cnt));
      waitUpdate();
      waitFrames(1);
      chk("R3 R6 frame length", lastLen, VEC[i].cnt);
      chk("R5 serial pattern", lastOut, {32'd0, VEC[i].outv} & maskOf(VEC[i].cnt));
      waitUpdate();
      chk("R7 R8 input word", inWord, {32'd0, VEC[i].inv} & maskOf(VEC[i].cnt));
    end

    // R9: output word changed just after a frame started
    lineCount = 6'd8; divider = 8'd1; outWord = 32'h0000_00C6;
    waitUpdate();
    waitUpdate();
    outWord = 32'h0000_0039;
    waitFrames(1);
    chk("R9 current frame keeps old word", lastOut, 64'hC6);
    waitFrames(1);
    chk("R9 next frame takes new word", lastOut, 64'h39);

    // R4: low half-period with divider 2
    divider = 8'd2; lineCount = 6'd4;
    waitUpdate();
    waitUpdate();
    while (busClk !== 1'b1) @(negedge clk);
    while (busClk !== 1'b0) @(negedge clk);
    begin
      int lowLen = 0;
      while (busClk === 1'b0) begin
        lowLen++;
        @(negedge clk);
      end
      chk("R4 low half-period", lowLen, 3);
    end

    // R10 / R2: disable mid-frame finishes the frame, then idles
    waitUpdate();
    enable = 1'b0;
    waitFrames(1);
    chk("R10 frame completes after disable", lastLen, 4);
    waitUpdate();
    idleWatch("R2 idle after disable", 40);

    // R2: enabled with zero lines stays idle
    lineCount = 6'd0; enable = 1'b1;
    idleWatch("R2 zero line count", 40);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule